// File: doc/BRIEF.md
# Three-Mode Power-Down Controller

This block decides when a small processor leaves normal execution for one of three low-power modes, and when it comes back. Software picks between a light sleep and a deeper software standby. It does this by executing a SLEEP instruction, which the CPU signals with a one-cycle strobe, while a software standby control bit selects the target mode. A third, deepest mode, hardware standby, is forced by an active-low standby pin. That pin overrides every other state and acts without waiting for a clock edge.

Each mode gates its own set of resources: the CPU clock, the peripheral clock, register retention, peripheral reset and I/O drive. Each mode also accepts its own set of wake sources. A four-state mode register holds the state, and the outputs are decoded from it together with a short counter. That counter times the partial peripheral reset issued on entry to software standby. The oscillator, the CPU, the interrupt controller and the peripherals are outside the block.

Top module: `pdmode_ctrl`

## Requirements
- R1: While rstN is low (and stbyN high), modeOut is 00 (run), with cpuClkEn=1, perClkEn=1, regRetain=1, perRstPart=0, perRstFull=0 and ioHiZ=0; after release the block stays in run until a request arrives.
- R2: In run, a sleepStrobe sampled with swStbyBit=0 moves modeOut to 01 (sleep) after that edge; in sleep cpuClkEn=0, perClkEn=1, regRetain=1 and ioHiZ=0.
- R3: In run, a sleepStrobe sampled with swStbyBit=1 and wdtRunning=0 moves modeOut to 10 (software standby); there cpuClkEn=0, perClkEn=0, regRetain=1 and ioHiZ=0.
- R4: In run, a sleepStrobe sampled with swStbyBit=1 while wdtRunning=1 enters sleep (01), never software standby.
- R5: In sleep, irqReq or nmiReq sampled high returns modeOut to 00 after that edge.
- R6: In software standby, irqReq has no effect on the mode; nmiReq sampled high returns modeOut to 00.
- R7: stbyN low forces modeOut to 11 (hardware standby) from any mode, without a clock edge; there cpuClkEn=0, perClkEn=0, regRetain=0, perRstFull=1 and ioHiZ=1. stbyN low takes precedence over rstN low.
- R8: Hardware standby is left only by rstN low while stbyN is high; irqReq, nmiReq and sleepStrobe leave it unchanged.
- R9: rstN low from sleep or software standby returns modeOut to 00.
- R10: perRstPart is high for exactly PART_RST_CYCLES sampled cycles (4 by default), starting with the first cycle of software standby, and only while in software standby.
- R11: sleepStrobe outside run has no effect on the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rstN | input | 1 | Active-low reset pin, asynchronous |
| stbyN | input | 1 | Active-low hardware standby pin, asynchronous |
| sleepStrobe | input | 1 | One-cycle strobe from the CPU when it executes SLEEP |
| swStbyBit | input | 1 | Software standby select bit |
| wdtRunning | input | 1 | High while the watchdog timer is counting |
| irqReq | input | 1 | Maskable interrupt request |
| nmiReq | input | 1 | Non-maskable interrupt request |
| cpuClkEn | output | 1 | CPU clock enable |
| perClkEn | output | 1 | Peripheral clock enable |
| regRetain | output | 1 | CPU register contents are kept |
| perRstPart | output | 1 | Partial peripheral reset request |
| perRstFull | output | 1 | Full peripheral reset request |
| ioHiZ | output | 1 | I/O pins to high impedance |
| modeOut | output | 2 | 00 run, 01 sleep, 10 software standby, 11 hardware standby |

## Verification
The bench probes the wake filters with requests each mode must ignore. An ordinary interrupt in software standby would wrongly restart the chip if the two wake sets were merged. An interrupt after the standby pin returns high would release hardware standby without a reset if its exit were not tied to rstN. The bench also sets the standby bit while the watchdog runs, which catches a design that drops into standby with a live watchdog. It pulls stbyN low between clock edges and expects ioHiZ at once, so a synchronous-only standby path would be reported. It also counts the partial-reset pulse exactly, to catch an off-by-one load.

// File: rtl/pdmode_pkg.sv
package pdmode_pkg;

  typedef enum logic [1:0] {
    PD_RUN    = 2'b00,
    PD_SLEEP  = 2'b01,
    PD_SWSTBY = 2'b10,
    PD_HWSTBY = 2'b11
  } pdMode_e;

  // strobes from the mode control to the output datapath
  typedef struct packed {
    logic swEntry;  // this edge enters software standby
    logic inSleep;
    logic inSw;
    logic inHw;
  } pdStrobe_t;

endpackage

// File: rtl/pdmode_fsm.sv
module pdmode_fsm
  import pdmode_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      stbyN,
  input  logic      sleepStrobe,
  input  logic      swStbyBit,
  input  logic      wdtRunning,
  input  logic      irqReq,
  input  logic      nmiReq,
  output pdMode_e   mode,
  output pdStrobe_t strb
);

  pdMode_e nextMode;
  logic    deepOk;

  // standby only when the watchdog cannot fire while the clock is stopped
  assign deepOk = swStbyBit && !wdtRunning;

  always_comb begin
    nextMode = mode;
    case (mode)
      PD_RUN: begin
        if (sleepStrobe) nextMode = deepOk ? PD_SWSTBY : PD_SLEEP;
      end
      PD_SLEEP: begin
        if (irqReq || nmiReq) nextMode = PD_RUN;
      end
      PD_SWSTBY: begin
        if (nmiReq) nextMode = PD_RUN;
      end
      PD_HWSTBY: begin
        nextMode = PD_HWSTBY;  // only the reset pin leaves
      end
      default: nextMode = PD_RUN;
    endcase
  end

  // standby pin dominates reset; both act without a clock edge
  always_ff @(posedge clk or negedge rstN or negedge stbyN) begin
    if (!stbyN)      mode <= PD_HWSTBY;
    else if (!rstN)  mode <= PD_RUN;
    else             mode <= nextMode;
  end

  always_comb begin
    strb.swEntry = (mode == PD_RUN) && (nextMode == PD_SWSTBY);
    strb.inSleep = (mode == PD_SLEEP);
    strb.inSw    = (mode == PD_SWSTBY);
    strb.inHw    = (mode == PD_HWSTBY);
  end

endmodule

// File: rtl/pdmode_outs.sv
module pdmode_outs
  import pdmode_pkg::*;
#(
  parameter int PART_RST_CYCLES = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  pdStrobe_t strb,
  output logic      cpuClkEn,
  output logic      perClkEn,
  output logic      regRetain,
  output logic      perRstPart,
  output logic      perRstFull,
  output logic      ioHiZ
);

  localparam int CNT_W = $clog2(PART_RST_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PART_RST_CYCLES);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [CNT_W-1:0] partCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               partCnt <= '0;
    else if (strb.swEntry)   partCnt <= CNT_LOAD;
    else if (strb.inHw)      partCnt <= '0;
    else if (partCnt != '0)  partCnt <= partCnt - CNT_ONE;
  end

  always_comb begin
    cpuClkEn   = !(strb.inSleep || strb.inSw || strb.inHw);
    perClkEn   = !(strb.inSw || strb.inHw);
    regRetain  = !strb.inHw;
    perRstFull = strb.inHw;
    ioHiZ      = strb.inHw;
    perRstPart = strb.inSw && (partCnt != '0);
  end

endmodule

// File: rtl/pdmode_ctrl.sv
module pdmode_ctrl
  import pdmode_pkg::*;
#(
  parameter int PART_RST_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       stbyN,
  input  logic       sleepStrobe,
  input  logic       swStbyBit,
  input  logic       wdtRunning,
  input  logic       irqReq,
  input  logic       nmiReq,
  output logic       cpuClkEn,
  output logic       perClkEn,
  output logic       regRetain,
  output logic       perRstPart,
  output logic       perRstFull,
  output logic       ioHiZ,
  output logic [1:0] modeOut
);

  pdMode_e   mode;
  pdStrobe_t strb;

  pdmode_fsm u_fsm (
    .clk        (clk),
    .rstN       (rstN),
    .stbyN      (stbyN),
    .sleepStrobe(sleepStrobe),
    .swStbyBit  (swStbyBit),
    .wdtRunning (wdtRunning),
    .irqReq     (irqReq),
    .nmiReq     (nmiReq),
    .mode       (mode),
    .strb       (strb)
  );

  pdmode_outs #(.PART_RST_CYCLES(PART_RST_CYCLES)) u_outs (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .cpuClkEn  (cpuClkEn),
    .perClkEn  (perClkEn),
    .regRetain (regRetain),
    .perRstPart(perRstPart),
    .perRstFull(perRstFull),
    .ioHiZ     (ioHiZ)
  );

  assign modeOut = mode;

endmodule

// File: rtl/pdmode_chk.sv
module pdmode_chk (
  input logic       clk,
  input logic       rstN,
  input logic       stbyN,
  input logic       sleepStrobe,
  input logic       wdtRunning,
  input logic       nmiReq,
  input logic       cpuClkEn,
  input logic       perClkEn,
  input logic       regRetain,
  input logic       perRstPart,
  input logic       ioHiZ,
  input logic [1:0] modeOut
);

  // R7
  stby_forces_hw_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stbyN |-> (modeOut == 2'b11) && ioHiZ && !regRetain);

  // R8
  hw_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeOut == 2'b11) |=> (modeOut == 2'b11));

  // R6
  sw_irq_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeOut == 2'b10) && !nmiReq && stbyN |=> (modeOut == 2'b10) || !stbyN);

  // R3
  sw_clocks_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeOut == 2'b10) |-> !cpuClkEn && !perClkEn && regRetain);

  // R4
  wdt_guard_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeOut == 2'b00) && sleepStrobe && wdtRunning && stbyN
      |=> (modeOut == 2'b01) || !stbyN);

  // R10
  part_only_sw_chk: assert property (@(posedge clk) disable iff (!rstN)
    perRstPart |-> (modeOut == 2'b10));

  // R2
  cpu_clk_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuClkEn |-> (modeOut == 2'b00));

endmodule

bind pdmode_ctrl pdmode_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .stbyN      (stbyN),
  .sleepStrobe(sleepStrobe),
  .wdtRunning (wdtRunning),
  .nmiReq     (nmiReq),
  .cpuClkEn   (cpuClkEn),
  .perClkEn   (perClkEn),
  .regRetain  (regRetain),
  .perRstPart (perRstPart),
  .ioHiZ      (ioHiZ),
  .modeOut    (modeOut)
);

// File: tb/sim_pdmode_ctrl.sv
module sim_pdmode_ctrl;

  localparam logic [1:0] RUN = 2'b00, SLP = 2'b01, SWS = 2'b10, HWS = 2'b11;

  logic clk = 1'b0;
  logic rstN, stbyN, sleepStrobe, swStbyBit, wdtRunning, irqReq, nmiReq;
  logic cpuClkEn, perClkEn, regRetain, perRstPart, perRstFull, ioHiZ;
  logic [1:0] modeOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t q[$];

  always #2 clk = ~clk;  // 250 MHz

  pdmode_ctrl u0 (
    .clk(clk), .rstN(rstN), .stbyN(stbyN), .sleepStrobe(sleepStrobe),
    .swStbyBit(swStbyBit), .wdtRunning(wdtRunning), .irqReq(irqReq),
    .nmiReq(nmiReq), .cpuClkEn(cpuClkEn), .perClkEn(perClkEn),
    .regRetain(regRetain), .perRstPart(perRstPart), .perRstFull(perRstFull),
    .ioHiZ(ioHiZ), .modeOut(modeOut)
  );

  // {mode, cpuClk, perClk, retain, part, full, hiZ} as the requirements state
  function automatic logic [7:0] expVec(input logic [1:0] m, input logic p);
    case (m)
      RUN:     expVec = {RUN, 1'b1, 1'b1, 1'b1, p,    1'b0, 1'b0};
      SLP:     expVec = {SLP, 1'b0, 1'b1, 1'b1, p,    1'b0, 1'b0};
      SWS:     expVec = {SWS, 1'b0, 1'b0, 1'b1, p,    1'b0, 1'b0};
      default: expVec = {HWS, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1};
    endcase
  endfunction

  function automatic logic [7:0] actVec();
    actVec = {modeOut, cpuClkEn, perClkEn, regRetain, perRstPart, perRstFull, ioHiZ};
  endfunction

  task automatic compare(input logic [7:0] exp, input string tag);
    logic [7:0] act;
    act = actVec();
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: outputs %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // driver: apply one cycle of inputs, queue the state expected after the edge
  task automatic cyc(input logic slp, input logic swb, input logic wdt,
                     input logic irq, input logic nmi, input logic rn,
                     input logic sn, input logic [1:0] em, input logic ep,
                     input string tag);
    item_t it;
    @(negedge clk);
    sleepStrobe = slp; swStbyBit = swb; wdtRunning = wdt;
    irqReq = irq; nmiReq = nmi; rstN = rn; stbyN = sn;
    it.exp = expVec(em, ep);
    it.tag = tag;
    q.push_back(it);
  endtask

  // R7: standby pin acts between clock edges
  task automatic asyncStby();
    @(negedge clk);
    sleepStrobe = 1'b0; swStbyBit = 1'b0; wdtRunning = 1'b0;
    irqReq = 1'b0; nmiReq = 1'b0;
    stbyN = 1'b0;
    #1;
    compare(expVec(HWS, 1'b0), "R7 async");
  endtask

  // monitor: compare away from the active edge
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      compare(it.exp, it.tag);
    end
  end

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run still active, expected completion");
      finishRun();
    end
  end

  initial begin
    rstN = 1'b0; stbyN = 1'b1; sleepStrobe = 1'b0; swStbyBit = 1'b0;
    wdtRunning = 1'b0; irqReq = 1'b0; nmiReq = 1'b0;

    // R1 reset and idle
    cyc(0,0,0,0,0, 0,1, RUN,0, "R1 reset");
    cyc(0,0,0,0,0, 0,1, RUN,0, "R1 reset");
    cyc(0,0,0,0,0, 1,1, RUN,0, "R1 idle");
    cyc(0,1,0,1,1, 1,1, RUN,0, "R1 idle");

    // R2 sleep, R11 strobe ignored, R5 irq wake
    cyc(1,0,0,0,0, 1,1, SLP,0, "R2 enter");
    cyc(0,0,0,0,0, 1,1, SLP,0, "R2 hold");
    cyc(1,1,0,0,0, 1,1, SLP,0, "R11 sleep");
    cyc(0,0,0,1,0, 1,1, RUN,0, "R5 irq");

    // R4 watchdog guard, R5 nmi wake
    cyc(1,1,1,0,0, 1,1, SLP,0, "R4 guard");
    cyc(0,0,0,0,1, 1,1, RUN,0, "R5 nmi");

    // R3 software standby, R10 partial reset window, R6 wake filter
    cyc(1,1,0,0,0, 1,1, SWS,1, "R3 enter");
    cyc(0,1,0,1,0, 1,1, SWS,1, "R6 irq");
    cyc(1,1,0,1,0, 1,1, SWS,1, "R11 swstby");
    cyc(0,0,0,0,0, 1,1, SWS,1, "R10 last");
    cyc(0,0,0,0,0, 1,1, SWS,0, "R10 end");
    cyc(0,0,0,1,0, 1,1, SWS,0, "R6 irq");
    cyc(0,0,0,0,1, 1,1, RUN,0, "R6 nmi");

    // R9 reset from sleep and from software standby
    cyc(1,0,0,0,0, 1,1, SLP,0, "R2 enter");
    cyc(0,0,0,0,0, 0,1, RUN,0, "R9 sleep");
    cyc(0,0,0,0,0, 1,1, RUN,0, "R9 release");
    cyc(1,1,0,0,0, 1,1, SWS,1, "R3 enter");
    cyc(0,0,0,0,0, 0,1, RUN,0, "R9 swstby");
    cyc(0,0,0,0,0, 1,1, RUN,0, "R9 release");

    // R7 from software standby, R8 exit rule
    cyc(1,1,0,0,0, 1,1, SWS,1, "R3 enter");
    asyncStby();
    cyc(0,0,0,0,1, 1,0, HWS,0, "R8 nmi low pin");
    cyc(0,0,0,1,0, 1,1, HWS,0, "R8 irq");
    cyc(1,0,0,0,1, 1,1, HWS,0, "R8 nmi");
    cyc(0,0,0,0,0, 0,1, RUN,0, "R8 reset exit");
    cyc(0,0,0,0,0, 1,1, RUN,0, "R1 release");

    // R7 from sleep
    cyc(1,0,0,0,0, 1,1, SLP,0, "R2 enter");
    cyc(0,0,0,1,0, 1,0, HWS,0, "R7 sleep");
    cyc(0,0,0,0,0, 1,1, HWS,0, "R8 pin high");
    cyc(0,0,0,0,0, 0,1, RUN,0, "R8 reset exit");
    cyc(0,0,0,0,0, 1,1, RUN,0, "R1 release");

    // R7 from run, and priority over reset
    cyc(0,0,0,0,0, 1,0, HWS,0, "R7 run");
    cyc(0,0,0,0,0, 0,0, HWS,0, "R7 priority");
    cyc(0,0,0,0,0, 0,1, RUN,0, "R8 reset exit");
    cyc(0,0,0,0,0, 1,1, RUN,0, "R1 release");

    // R10 window counted again after a full cycle of modes
    cyc(1,1,0,0,0, 1,1, SWS,1, "R10 first");
    cyc(0,1,0,0,0, 1,1, SWS,1, "R10 second");
    cyc(0,1,0,0,0, 1,1, SWS,1, "R10 third");
    cyc(0,1,0,0,0, 1,1, SWS,1, "R10 fourth");
    cyc(0,1,0,0,0, 1,1, SWS,0, "R10 fifth");
    cyc(0,0,0,0,1, 1,1, RUN,0, "R6 nmi");

    repeat (3) @(negedge clk);
    done = 1'b1;
    finishRun();
  end

endmodule